// File: doc/BRIEF.md
# TLB Entry Access Port

This block gives software a register-level window into a unified translation look-aside buffer. It keeps an array of entries, each made of a tag-side high word, a process tag captured beside it, and a data-side low word that carries page attribute bits. An index register chooses the entry. Special-register read and write strobes, decoded from a selector code, reach the chosen entry's high or low word, the index register itself, or the process-ID register.

The process-ID register is tied to the high-word accesses. Writing the high word stamps the current process ID into the entry's tag. Reading the high word in supervisor mode copies that tag back into the process-ID register. Two attribute bits are constrained. The memory-coherent bit is fixed at zero. The write-through bit is fixed at one unless the build enables write-back caching. Lookup, translation and fault generation are handled elsewhere. This block only stores entries and enforces the access rules.

Top module: `tlbp_access_port`

## Requirements
- R1: After a synchronous active-low reset, every high word and every process tag is 0, the index and process-ID registers are 0, `rd_valid` is 0, and every low word reads 0x00000008 when write-back is disabled and 0x00000000 when it is enabled.
- R2: A read strobe accepted in cycle t makes `rd_valid` high with its data in cycle t+1 and in no other cycle. A selector other than 0x1000 (process ID), 0x1002 (index), 0x1003 (low word) or 0x1004 (high word) returns 0.
- R3: A write at selector 0x1004 stores the full 32-bit data as the indexed entry's high word and copies the current process-ID value into that entry's tag. A later read at 0x1004 returns the stored word.
- R4: A read at 0x1004 while `user_mode` is 0 loads the indexed entry's tag into the process-ID register. The new value shows on `cur_pid` in the same cycle as the returned data.
- R5: A read at 0x1004 while `user_mode` is 1 leaves the process-ID register unchanged.
- R6: The low word's attributes sit in bits 3..0: bit 3 write-through, bit 2 cache-inhibit, bit 1 coherent, bit 0 guarded. Bits 31..4 and bits 2 and 0 are stored and read back exactly as written at selector 0x1003.
- R7: Low-word bit 1 (coherent) always reads 0, whatever was written.
- R8: With `WRITEBACK_EN`=0, low-word bit 3 always reads 1 and writes to it have no effect. With `WRITEBACK_EN`=1, it reads back as written.
- R9: A write at 0x1002 keeps the low clog2(`NUM_ENTRIES`) bits of the data. If that value is `NUM_ENTRIES` or more, `NUM_ENTRIES` is subtracted. The result is stored, read back at 0x1002, and used to select the entry for all entry accesses.
- R10: A write at 0x1000 stores the low `PID_W` bits as the process ID. A read at 0x1000 returns it zero-extended.
- R11: If the read and write strobes are high in the same cycle, only the write takes place, and `rd_valid` stays 0 in the next cycle.
- R12: `cur_pid` always shows the process-ID register, and its value changes only through R4 or R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Special-register write strobe |
| reg_rd_en | input | 1 | Special-register read strobe |
| reg_sel | input | 14 | Selector code of the register accessed |
| reg_wdata | input | 32 | Write data |
| user_mode | input | 1 | High when the processor runs in user mode |
| rd_valid | output | 1 | Read data valid, one cycle after the read strobe |
| rd_data | output | 32 | Read data, zero when `rd_valid` is low |
| cur_pid | output | PID_W | Current process-ID register |

## Verification
The bench builds two copies of the block side by side from one stimulus stream.

The first copy has 48 entries and write-back disabled. That build exercises the subtract-on-overflow path of the index reduction and the forcing of the write-through bit to 1.

The second copy has 64 entries and write-back enabled. That build exercises plain power-of-two masking and a freely writable write-through bit.

Directed sequences on both copies cover the process-ID side effects of high-word reads in each mode, the read/write collision, and unknown selectors. A long random stream then mixes all selectors and modes against the behavioural model.

// File: rtl/tlbp_pkg.sv
// Package tlbp_pkg
// Shared selector codes, attribute bit positions and the low-word clean-up
// function used by the TLB access port. Assumes a 14-bit selector space.
package tlbp_pkg;

    localparam int SEL_W  = 14;
    localparam int WORD_W = 32;

    localparam logic [SEL_W-1:0] SEL_PID   = 14'h1000;
    localparam logic [SEL_W-1:0] SEL_INDEX = 14'h1002;
    localparam logic [SEL_W-1:0] SEL_LO    = 14'h1003;
    localparam logic [SEL_W-1:0] SEL_HI    = 14'h1004;

    // Attribute bit positions in the low word
    localparam int ATTR_GUARD = 0;
    localparam int ATTR_COHER = 1;
    localparam int ATTR_INHIB = 2;
    localparam int ATTR_WTHRU = 3;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PID,
        ACC_INDEX,
        ACC_LO,
        ACC_HI
    } acc_kind_e;

    // Decode a selector code into an access kind
    function automatic acc_kind_e decode_sel(input logic [SEL_W-1:0] sel);
        acc_kind_e k;
        case (sel)
            SEL_PID:   k = ACC_PID;
            SEL_INDEX: k = ACC_INDEX;
            SEL_LO:    k = ACC_LO;
            SEL_HI:    k = ACC_HI;
            default:   k = ACC_NONE;
        endcase
        return k;
    endfunction

    // Apply the fixed attribute rules to a low word
    function automatic logic [WORD_W-1:0] clean_lo(input logic [WORD_W-1:0] v,
                                                   input logic wb_en);
        logic [WORD_W-1:0] r;
        r = v;
        r[ATTR_COHER] = 1'b0;
        if (!wb_en) begin
            r[ATTR_WTHRU] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tlbp_index_reg.sv
// Module tlbp_index_reg
// Holds the entry index. On a write it keeps the low IDX_W bits of the data.
// When the entry count is not a power of two, values at or above it are
// reduced by one subtraction. The stored index is therefore always valid.
// Assumes NUM_ENTRIES >= 2.
module tlbp_index_reg #(
    parameter int NUM_ENTRIES = 64,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    output logic [IDX_W-1:0] idx
);

    localparam int SPAN = 1 << IDX_W;

    logic [IDX_W-1:0] raw_idx;
    logic [IDX_W-1:0] red_idx;

    assign raw_idx = wdata[IDX_W-1:0];

    generate
        if (SPAN == NUM_ENTRIES) begin : g_pow2
            // Power-of-two count: masking alone keeps the index in range
            assign red_idx = raw_idx;
        end else begin : g_wrap
            localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_ENTRIES);
            // Other counts: subtract the count once when the index overflows
            always_comb begin
                red_idx = raw_idx;
                if (raw_idx >= LIMIT) begin
                    red_idx = raw_idx - LIMIT;
                end
            end
        end
    endgenerate

    // Register the reduced index on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (wr_en) begin
            idx <= red_idx;
        end
    end

    assert_index_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idx) < NUM_ENTRIES);

    assert_index_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(idx));

endmodule

// File: rtl/tlbp_pid_reg.sv
// Module tlbp_pid_reg
// Process-ID register. Software writes it directly. A supervisor read of a
// high word loads it from the entry's tag. Assumes the two updates never
// happen in the same cycle; the top module's decode guarantees that.
module tlbp_pid_reg #(
    parameter int PID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic             load_en,
    input  logic [PID_W-1:0] load_val,
    output logic [PID_W-1:0] pid
);

    // Update from a direct write or from a tag load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid <= '0;
        end else if (wr_en) begin
            pid <= wdata[PID_W-1:0];
        end else if (load_en) begin
            pid <= load_val;
        end
    end

    assert_pid_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pid == $past(wdata[PID_W-1:0]));

    assert_pid_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !load_en) |=> $stable(pid));

    assert_pid_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && load_en));

endmodule

// File: rtl/tlbp_entry_array.sv
// Module tlbp_entry_array
// Flop-based storage for all entries: high word, process tag and low word.
// A high-word write also captures the current process ID as the tag.
// Low-word writes go through the attribute rules, and the write-back
// variant is chosen at elaboration. The read outputs are combinational
// views of the entry selected by idx, which is assumed in range.
module tlbp_entry_array #(
    parameter int NUM_ENTRIES  = 64,
    parameter int IDX_W        = $clog2(NUM_ENTRIES),
    parameter int PID_W        = 8,
    parameter bit WRITEBACK_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             hi_we,
    input  logic             lo_we,
    input  logic [31:0]      wdata,
    input  logic [PID_W-1:0] pid,
    output logic [31:0]      hi_q,
    output logic [PID_W-1:0] tid_q,
    output logic [31:0]      lo_q
);

    import tlbp_pkg::*;

    logic [31:0]      hi_arr  [NUM_ENTRIES];
    logic [PID_W-1:0] tid_arr [NUM_ENTRIES];
    logic [31:0]      lo_arr  [NUM_ENTRIES];
    logic [31:0]      lo_wval;
    logic [31:0]      lo_rst;

    generate
        if (WRITEBACK_EN) begin : g_wb
            // Write-back build: write-through bit is free, reset clears it
            assign lo_rst  = 32'h0;
            assign lo_wval = clean_lo(wdata, 1'b1);
        end else begin : g_wt
            // Write-through-only build: the bit is held at one
            assign lo_rst  = 32'h0 | (32'h1 << ATTR_WTHRU);
            assign lo_wval = clean_lo(wdata, 1'b0);
        end
    endgenerate

    // Reset every entry, then apply writes to the indexed entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                hi_arr[e]  <= '0;
                tid_arr[e] <= '0;
                lo_arr[e]  <= lo_rst;
            end
        end else begin
            if (hi_we) begin
                hi_arr[idx]  <= wdata;
                tid_arr[idx] <= pid;
            end
            if (lo_we) begin
                lo_arr[idx] <= lo_wval;
            end
        end
    end

    assign hi_q  = hi_arr[idx];
    assign tid_q = tid_arr[idx];
    assign lo_q  = lo_arr[idx];

    assert_tid_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> tid_arr[$past(idx)] == $past(pid));

    assert_hi_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> hi_arr[$past(idx)] == $past(wdata));

    assert_lo_coher_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> !lo_arr[$past(idx)][ATTR_COHER]);

endmodule

// File: rtl/tlbp_access_port.sv
// Module tlbp_access_port
// Top of the TLB entry access port. It decodes the special-register
// strobes, routes writes to the index, process-ID and entry storage, and
// returns read data one cycle after the read strobe. A supervisor read of a
// high word refreshes the process ID from the entry tag. When both strobes
// are high, the write wins and the read is dropped. Assumes the caller
// holds user_mode stable for the duration of each strobe.
module tlbp_access_port #(
    parameter int NUM_ENTRIES  = 64,
    parameter int PID_W        = 8,
    parameter bit WRITEBACK_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [13:0]      reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             user_mode,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic [PID_W-1:0] cur_pid
);

    import tlbp_pkg::*;

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    acc_kind_e        kind;
    logic             wr_acc;
    logic             rd_acc;
    logic [IDX_W-1:0] idx;
    logic [31:0]      hi_q;
    logic [PID_W-1:0] tid_q;
    logic [31:0]      lo_q;
    logic [31:0]      rd_mux;
    logic             pid_load;

    // Decode the selector and resolve strobe priority
    always_comb begin
        kind   = decode_sel(reg_sel);
        wr_acc = reg_wr_en;
        rd_acc = reg_rd_en && !reg_wr_en;
    end

    assign pid_load = rd_acc && (kind == ACC_HI) && !user_mode;

    tlbp_index_reg #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_acc && (kind == ACC_INDEX)),
        .wdata (reg_wdata),
        .idx   (idx)
    );

    tlbp_pid_reg #(
        .PID_W (PID_W)
    ) u_pid (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_acc && (kind == ACC_PID)),
        .wdata    (reg_wdata),
        .load_en  (pid_load),
        .load_val (tid_q),
        .pid      (cur_pid)
    );

    tlbp_entry_array #(
        .NUM_ENTRIES  (NUM_ENTRIES),
        .IDX_W        (IDX_W),
        .PID_W        (PID_W),
        .WRITEBACK_EN (WRITEBACK_EN)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (idx),
        .hi_we (wr_acc && (kind == ACC_HI)),
        .lo_we (wr_acc && (kind == ACC_LO)),
        .wdata (reg_wdata),
        .pid   (cur_pid),
        .hi_q  (hi_q),
        .tid_q (tid_q),
        .lo_q  (lo_q)
    );

    // Select the read source for the decoded selector
    always_comb begin
        case (kind)
            ACC_PID:   rd_mux = 32'(cur_pid);
            ACC_INDEX: rd_mux = 32'(idx);
            ACC_LO:    rd_mux = lo_q;
            ACC_HI:    rd_mux = hi_q;
            default:   rd_mux = 32'h0;
        endcase
    end

    // Register read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_acc;
            rd_data  <= rd_acc ? rd_mux : 32'h0;
        end
    end

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en) |=> rd_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> !rd_valid);

    assert_unknown_sel_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_sel != SEL_PID && reg_sel != SEL_INDEX &&
         reg_sel != SEL_LO && reg_sel != SEL_HI) |=> rd_data == 32'h0);

    assert_collision_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_rd_en) |=> !rd_valid);

    assert_pid_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_sel == SEL_HI && !user_mode)
        |=> cur_pid == $past(tid_q));

    assert_pid_user_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_sel == SEL_HI && user_mode)
        |=> $stable(cur_pid));

    assert_lo_read_coher_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !reg_wr_en && reg_sel == SEL_LO) |=> !rd_data[ATTR_COHER]);

    generate
        if (!WRITEBACK_EN) begin : g_wt_check
            assert_lo_read_wthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rd_en && !reg_wr_en && reg_sel == SEL_LO) |=> rd_data[ATTR_WTHRU]);
        end
    endgenerate

endmodule

// File: tb/tlbp_access_port_test.sv
// Bench for tlbp_access_port. Two builds share one stimulus stream:
// uut (48 entries, no write-back) and uut_wb (64 entries, write-back).
// A behavioural model predicts every output and is compared on every clock.
module tlbp_access_port_test;

    localparam logic [13:0] C_PID = 14'h1000;
    localparam logic [13:0] C_IDX = 14'h1002;
    localparam logic [13:0] C_LO  = 14'h1003;
    localparam logic [13:0] C_HI  = 14'h1004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [13:0] reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        user_mode = 1'b0;

    logic        v0, v1;
    logic [31:0] d0, d1;
    logic [7:0]  p0, p1;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string phase = "R1";

    always #2 clk = ~clk;

    tlbp_access_port #(.NUM_ENTRIES(48), .PID_W(8), .WRITEBACK_EN(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .user_mode(user_mode),
        .rd_valid(v0), .rd_data(d0), .cur_pid(p0));

    tlbp_access_port #(.NUM_ENTRIES(64), .PID_W(8), .WRITEBACK_EN(1'b1)) uut_wb (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .user_mode(user_mode),
        .rd_valid(v1), .rd_data(d1), .cur_pid(p1));

    // Behavioural model state, one slot per build
    logic [31:0] m_hi  [2][64];
    logic [7:0]  m_tid [2][64];
    logic [31:0] m_lo  [2][64];
    int          m_idx [2];
    logic [7:0]  m_pid [2];
    logic        m_rv  [2];
    logic [31:0] m_rd  [2];

    function automatic int nent(int k);
        return (k == 0) ? 48 : 64;
    endfunction

    function automatic void model_step(int k);
        logic [31:0] t;
        int v;
        if (!rst_n) begin
            for (int e = 0; e < 64; e++) begin
                m_hi[k][e] = 0;
                m_tid[k][e] = 0;
                m_lo[k][e] = (k == 1) ? 32'h0 : 32'h8;
            end
            m_idx[k] = 0; m_pid[k] = 0; m_rv[k] = 0; m_rd[k] = 0;
        end else begin
            m_rv[k] = 0; m_rd[k] = 0;
            if (reg_wr_en) begin
                case (reg_sel)
                    C_PID: m_pid[k] = reg_wdata[7:0];
                    C_IDX: begin
                        v = int'(reg_wdata & 32'h3F);
                        if (v >= nent(k)) v = v - nent(k);
                        m_idx[k] = v;
                    end
                    C_LO: begin
                        t = reg_wdata; t[1] = 1'b0;
                        if (k == 0) t[3] = 1'b1;
                        m_lo[k][m_idx[k]] = t;
                    end
                    C_HI: begin
                        m_hi[k][m_idx[k]] = reg_wdata;
                        m_tid[k][m_idx[k]] = m_pid[k];
                    end
                    default: ;
                endcase
            end else if (reg_rd_en) begin
                m_rv[k] = 1'b1;
                case (reg_sel)
                    C_PID: m_rd[k] = 32'(m_pid[k]);
                    C_IDX: m_rd[k] = 32'(m_idx[k]);
                    C_LO:  m_rd[k] = m_lo[k][m_idx[k]];
                    C_HI: begin
                        m_rd[k] = m_hi[k][m_idx[k]];
                        if (!user_mode) m_pid[k] = m_tid[k][m_idx[k]];
                    end
                    default: m_rd[k] = 32'h0;
                endcase
            end
        end
    endfunction

    // Advance the model on each rising edge
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) model_step(k);
    end

    function automatic void cmp(int k, logic v, logic [31:0] d, logic [7:0] p);
        vectors++;
        if (v !== m_rv[k] || d !== m_rd[k] || p !== m_pid[k]) begin
            fails++;
            $display("FAIL %s build%0d valid/data/pid got %b/%h/%h expected %b/%h/%h",
                     phase, k, v, d, p, m_rv[k], m_rd[k], m_pid[k]);
        end
    endfunction

    // Compare both builds against the model away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            cmp(0, v0, d0, p0);
            cmp(1, v1, d1, p1);
        end
    end

    function automatic void chk(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endfunction

    task automatic op(bit w, bit r, logic [13:0] s, logic [31:0] d, bit um);
        @(negedge clk);
        reg_wr_en = w; reg_rd_en = r; reg_sel = s; reg_wdata = d; user_mode = um;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog expired");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    localparam logic [13:0] SELS [5] = '{C_PID, C_IDX, C_LO, C_HI, 14'h1001};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid", 32'(v0), 0);
        chk("R1 pid", 32'(p0), 0);

        phase = "R1";
        for (int e = 0; e < 64; e++) begin
            op(1, 0, C_IDX, e, 0);
            op(0, 1, C_HI, 0, 0);
            chk("R1 hi", d1, 0);
            op(0, 1, C_LO, 0, 0);
            if (e < 48) chk("R1 lo wt", d0, 32'h8);
            chk("R1 lo wb", d1, 32'h0);
        end

        phase = "R10";
        op(1, 0, C_PID, 32'h1A5, 0);
        op(0, 1, C_PID, 0, 0);
        chk("R10 pid read", d0, 32'hA5);

        phase = "R3";
        op(1, 0, C_IDX, 7, 0);
        op(1, 0, C_HI, 32'hDEADBEEF, 0);
        op(1, 0, C_PID, 32'h33, 0);
        op(0, 1, C_HI, 0, 1);
        chk("R3 hi data", d0, 32'hDEADBEEF);
        chk("R5 pid kept", 32'(p0), 32'h33);
        phase = "R4";
        op(0, 1, C_HI, 0, 0);
        chk("R4 pid loaded", 32'(p0), 32'hA5);
        chk("R4 pid loaded wb", 32'(p1), 32'hA5);

        phase = "R6";
        op(1, 0, C_IDX, 9, 0);
        op(1, 0, C_LO, 32'hFFFFFFFF, 0);
        op(0, 1, C_LO, 0, 0);
        chk("R7 lo all ones", d0, 32'hFFFFFFFD);
        chk("R7 lo all ones wb", d1, 32'hFFFFFFFD);
        op(1, 0, C_LO, 32'h0, 0);
        op(0, 1, C_LO, 0, 0);
        chk("R8 w forced", d0, 32'h8);
        chk("R8 w writable", d1, 32'h0);
        op(1, 0, C_LO, 32'h5, 0);
        op(0, 1, C_LO, 0, 0);
        chk("R6 i g kept", d0, 32'hD);
        chk("R6 i g kept wb", d1, 32'h5);

        phase = "R9";
        op(1, 0, C_IDX, 50, 0);
        op(0, 1, C_IDX, 0, 0);
        chk("R9 wrap", d0, 2);
        chk("R9 no wrap", d1, 50);
        op(1, 0, C_IDX, 32'hFFFFFFC5, 0);
        op(0, 1, C_IDX, 0, 0);
        chk("R9 mask", d0, 5);
        chk("R9 mask wb", d1, 5);

        phase = "R11";
        op(1, 1, C_PID, 32'h77, 0);
        chk("R11 read dropped", 32'(v0), 0);
        chk("R11 write done", 32'(p0), 32'h77);

        phase = "R2";
        op(0, 1, 14'h1FFF, 0, 0);
        chk("R2 unknown valid", 32'(v0), 1);
        chk("R2 unknown data", d0, 0);

        phase = "R12";
        for (int i = 0; i < 3000; i++) begin
            op(1'($urandom), 1'($urandom), SELS[$urandom % 5], $urandom, 1'($urandom));
        end

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule